// File: doc/BRIEF.md
# Frequency Hop List Controller

This block keeps a table of up to 32 signed frequency offsets, in 1 Hz units relative to the carrier, and drives the offset of the entry that is currently selected. A hop request moves the selection to a new entry. The index of the new entry comes from one of three sources, chosen by a mode input:
- the following table position, with wrap-around;
- a pseudo-random sequence generator whose length and start value can be set;
- an address bus supplied from outside the block.

Hops are aligned to symbol boundaries. A request waits until the next symbol strobe before it takes effect. After a hop has been accepted, the block ignores further requests for one symbol, so two hops are never closer together than two symbol periods.

The table is loaded through a simple write port. Any value written beyond the allowed offset range is saturated to that range before it is stored. The number of active entries comes from a length input, and every index source is kept inside that length.

Top module: `hop_list_ctrl`

## Requirements
- R1: A table write stores `wr_data` as a 25-bit two's complement value. Values above +10,000,000 are stored as +10,000,000, and values below -10,000,000 are stored as -10,000,000. Values within the range are stored unchanged.
- R2: `offset_out` always shows the stored entry at `cur_idx`. A write to that entry appears on `offset_out` one cycle after the write. After reset, `cur_idx` is 0 and every entry is 0.
- R3: A `hop_trig` pulse makes a request pending. The request is accepted on the first clock edge, after the edge that captured the pulse, at which `sym_stb` is high. A trigger that arrives together with a strobe therefore waits for the next strobe. The new `cur_idx` and a one-cycle `hop_done` pulse appear in the cycle after the accepting strobe. Without a hop, `cur_idx` does not change.
- R4: The block drops any trigger that arrives in the accepting strobe cycle. It also drops any trigger that arrives from then up to and including the next strobe cycle. Consecutive accepted hops are therefore at least two strobes apart.
- R5: When `hop_mode` is 0 or 3 (linear mode), a hop moves to `cur_idx`+1. From effective length − 1 or higher, it moves to 0.
- R6: When `hop_mode` is 1 (random mode), the new index is the low 5 bits of the generator state, taken modulo the effective length. The generator then steps once. Each step shifts left by one, inserts the XOR of the tap bits at bit 0, and masks the result to the selected length. The `pn_sel` codes are:

  | `pn_sel` | Length | Tap bits (bit 0 = LSB) |
  |---|---|---|
  | 0 | 9 | 8, 4 |
  | 1 | 11 | 10, 8 |
  | 2 | 15 | 14, 13 |
  | 3 | 16 | 15, 14, 12, 3 |
  | 4 | 20 | 19, 2 |
  | 5 | 21 | 20, 18 |
  | 6 or 7 | 23 | 22, 17 |

- R7: `seed_load` loads `pn_seed`, masked to the selected length. A masked value of zero is replaced by 1. After reset, the generator state is 1.
- R8: When `hop_mode` is 2 (external mode), the new index is `ext_addr`, captured in the cycle the trigger was taken, modulo the effective length.
- R9: The effective length is `list_len`. When `list_len` is 0 or greater than 32, the effective length is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 5 | Table write index |
| wr_data | input | 25 | Signed offset to write (Hz) |
| hop_mode | input | 2 | 0/3 linear, 1 random, 2 external |
| pn_sel | input | 3 | Generator length code |
| pn_seed | input | 23 | Generator start value |
| seed_load | input | 1 | Load `pn_seed` into the generator |
| hop_trig | input | 1 | Hop request |
| ext_addr | input | 5 | External index |
| sym_stb | input | 1 | Symbol boundary strobe |
| list_len | input | 6 | Number of active entries |
| cur_idx | output | 5 | Selected table index |
| offset_out | output | 25 | Signed offset of the selected entry |
| hop_done | output | 1 | One-cycle pulse after an accepted hop |

## Verification
The spacing and alignment assertions assume that `sym_stb` is the only event that marks a symbol. They also assume that `hop_done` is registered one edge after the accepting strobe, so the checker counts strobes starting from that pulse. The stimulus keeps strobes separated by idle cycles and holds every control input stable across the clock edge. It drives triggers on purpose inside the hold-off window and in the same cycle as strobes, so that both dropped requests and deferred requests are observed. The range assertion on `offset_out` relies on every write passing through the saturation path. The stimulus includes writes that go beyond the limit in both directions.

// File: rtl/hop_pkg.sv
`timescale 1ns/1ps
package hop_pkg;

    // Widest supported generator length
    localparam int PN_MAX_W = 23;

    typedef enum logic [1:0] {
        HOP_LINEAR = 2'd0,
        HOP_RANDOM = 2'd1,
        HOP_EXTERN = 2'd2,
        HOP_LIN_B  = 2'd3
    } hop_mode_e;

    // Register length chosen by a length code
    function automatic int unsigned pn_length(input logic [2:0] sel);
        case (sel)
            3'd0:    pn_length = 9;
            3'd1:    pn_length = 11;
            3'd2:    pn_length = 15;
            3'd3:    pn_length = 16;
            3'd4:    pn_length = 20;
            3'd5:    pn_length = 21;
            default: pn_length = 23;
        endcase
    endfunction

    function automatic logic [PN_MAX_W-1:0] pn_mask(input logic [2:0] sel);
        logic [PN_MAX_W-1:0] m;
        int unsigned len;
        len = pn_length(sel);
        for (int b = 0; b < PN_MAX_W; b++) begin
            m[b] = (b < len);
        end
        return m;
    endfunction

endpackage

// File: rtl/hop_ofs_store.sv
`timescale 1ns/1ps
module hop_ofs_store #(
    parameter int ENTRIES   = 32,
    parameter int OFS_W     = 25,
    parameter int OFS_LIMIT = 10_000_000,
    parameter int ADDR_W    = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [OFS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [OFS_W-1:0]  rd_data
);

    localparam logic signed [OFS_W-1:0] LIM_POS = OFS_W'(OFS_LIMIT);
    localparam logic signed [OFS_W-1:0] LIM_NEG = -LIM_POS;

    logic signed [OFS_W-1:0] wr_sat;
    logic signed [OFS_W-1:0] ent_vec [ENTRIES];

    // Saturate once, shared by every entry
    always_comb begin
        if (wr_data > LIM_POS) begin
            wr_sat = LIM_POS;
        end else if (wr_data < LIM_NEG) begin
            wr_sat = LIM_NEG;
        end else begin
            wr_sat = wr_data;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic signed [OFS_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_addr == ADDR_W'(e))) begin
                ent_d = wr_sat;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_vec[e] = ent_q;
    end

    assign rd_data = ent_vec[rd_addr];

endmodule

// File: rtl/hop_prbs.sv
`timescale 1ns/1ps
module hop_prbs
    import hop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           pn_sel,
    input  logic                 load,
    input  logic [PN_MAX_W-1:0]  seed,
    input  logic                 step,
    output logic [PN_MAX_W-1:0]  state
);

    typedef struct packed {
        logic [PN_MAX_W-1:0] sr;
    } prbs_st_t;

    prbs_st_t st_d, st_q;
    logic                fb;
    logic [PN_MAX_W-1:0] mask;
    logic [PN_MAX_W-1:0] shifted;
    logic [PN_MAX_W-1:0] seeded;

    always_comb begin
        mask = pn_mask(pn_sel);
        case (pn_sel)
            3'd0:    fb = st_q.sr[8]  ^ st_q.sr[4];
            3'd1:    fb = st_q.sr[10] ^ st_q.sr[8];
            3'd2:    fb = st_q.sr[14] ^ st_q.sr[13];
            3'd3:    fb = st_q.sr[15] ^ st_q.sr[14] ^ st_q.sr[12] ^ st_q.sr[3];
            3'd4:    fb = st_q.sr[19] ^ st_q.sr[2];
            3'd5:    fb = st_q.sr[20] ^ st_q.sr[18];
            default: fb = st_q.sr[22] ^ st_q.sr[17];
        endcase
        shifted = {st_q.sr[PN_MAX_W-2:0], fb} & mask;
        seeded  = seed & mask;

        st_d = st_q;
        if (load) begin
            st_d.sr = (seeded == '0) ? PN_MAX_W'(1) : seeded;
        end else if (step) begin
            st_d.sr = (shifted == '0) ? PN_MAX_W'(1) : shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr <= PN_MAX_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.sr;

endmodule

// File: rtl/hop_sched.sv
`timescale 1ns/1ps
module hop_sched #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hop_trig,
    input  logic              sym_stb,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              accept,
    output logic [ADDR_W-1:0] ext_held
);

    typedef struct packed {
        logic              pending;
        logic              holdoff;
        logic [ADDR_W-1:0] addr;
    } sched_st_t;

    sched_st_t st_d, st_q;
    logic      take;

    always_comb begin
        st_d   = st_q;
        accept = sym_stb && st_q.pending;
        take   = hop_trig && !st_q.holdoff && !accept;

        if (accept) begin
            st_d.pending = 1'b0;
            st_d.holdoff = 1'b1;
        end else begin
            if (sym_stb) begin
                st_d.holdoff = 1'b0;
            end
            if (take) begin
                st_d.pending = 1'b1;
                st_d.addr    = ext_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_held = st_q.addr;

endmodule

// File: rtl/hop_list_ctrl.sv
`timescale 1ns/1ps
module hop_list_ctrl
    import hop_pkg::*;
#(
    parameter int ENTRIES   = 32,
    parameter int OFS_W     = 25,
    parameter int OFS_LIMIT = 10_000_000,
    parameter int IDX_W     = $clog2(ENTRIES),
    parameter int LEN_W     = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic signed [OFS_W-1:0] wr_data,
    input  logic [1:0]              hop_mode,
    input  logic [2:0]              pn_sel,
    input  logic [PN_MAX_W-1:0]     pn_seed,
    input  logic                    seed_load,
    input  logic                    hop_trig,
    input  logic [IDX_W-1:0]        ext_addr,
    input  logic                    sym_stb,
    input  logic [LEN_W-1:0]        list_len,
    output logic [IDX_W-1:0]        cur_idx,
    output logic signed [OFS_W-1:0] offset_out,
    output logic                    hop_done
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(ENTRIES);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             done;
    } sel_st_t;

    sel_st_t st_d, st_q;

    logic                accept;
    logic [IDX_W-1:0]    ext_held;
    logic [PN_MAX_W-1:0] pn_state;
    logic                pn_step;
    logic [LEN_W-1:0]    eff_len;
    logic [LEN_W-1:0]    raw_idx;
    logic [LEN_W-1:0]    nxt_idx;
    hop_mode_e           mode;

    assign mode    = hop_mode_e'(hop_mode);
    assign eff_len = ((list_len == '0) || (list_len > FULL_LEN)) ? FULL_LEN : list_len;
    assign pn_step = accept && (mode == HOP_RANDOM);

    hop_sched #(.ADDR_W(IDX_W)) sched_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hop_trig (hop_trig),
        .sym_stb  (sym_stb),
        .ext_addr (ext_addr),
        .accept   (accept),
        .ext_held (ext_held)
    );

    hop_prbs prbs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pn_sel (pn_sel),
        .load   (seed_load),
        .seed   (pn_seed),
        .step   (pn_step),
        .state  (pn_state)
    );

    hop_ofs_store #(
        .ENTRIES   (ENTRIES),
        .OFS_W     (OFS_W),
        .OFS_LIMIT (OFS_LIMIT),
        .ADDR_W    (IDX_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (st_q.idx),
        .rd_data (offset_out)
    );

    // Index source selection
    always_comb begin
        case (mode)
            HOP_RANDOM: raw_idx = {1'b0, pn_state[IDX_W-1:0]};
            HOP_EXTERN: raw_idx = {1'b0, ext_held};
            default:    raw_idx = {1'b0, st_q.idx} + LEN_W'(1);
        endcase

        if (mode == HOP_RANDOM || mode == HOP_EXTERN) begin
            nxt_idx = raw_idx % eff_len;
        end else begin
            nxt_idx = (raw_idx >= eff_len) ? '0 : raw_idx;
        end

        st_d      = st_q;
        st_d.done = accept;
        if (accept) begin
            st_d.idx = nxt_idx[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_idx  = st_q.idx;
    assign hop_done = st_q.done;

endmodule

// File: rtl/hop_list_chk.sv
`timescale 1ns/1ps
module hop_list_chk #(
    parameter int IDX_W     = 5,
    parameter int OFS_W     = 25,
    parameter int OFS_LIMIT = 10_000_000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sym_stb,
    input logic                    hop_done,
    input logic [IDX_W-1:0]        cur_idx,
    input logic signed [OFS_W-1:0] offset_out
);

    localparam logic signed [OFS_W-1:0] LIM_POS = OFS_W'(OFS_LIMIT);
    localparam logic signed [OFS_W-1:0] LIM_NEG = -LIM_POS;

    // Strobes seen since the strobe that produced the last hop_done
    logic [1:0] stb_cnt_d, stb_cnt_q;

    always_comb begin
        if (hop_done) begin
            stb_cnt_d = sym_stb ? 2'd1 : 2'd0;
        end else if (sym_stb && stb_cnt_q != 2'd3) begin
            stb_cnt_d = stb_cnt_q + 2'd1;
        end else begin
            stb_cnt_d = stb_cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_cnt_q <= 2'd2;
        end else begin
            stb_cnt_q <= stb_cnt_d;
        end
    end

    // R3
    hop_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hop_done |-> $past(sym_stb));

    // R3
    idx_moves_on_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx != $past(cur_idx)) |-> hop_done);

    // R4
    hop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hop_done |-> (stb_cnt_q >= 2'd2));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hop_done |=> !hop_done);

    // R1
    ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_out <= LIM_POS) && (offset_out >= LIM_NEG));

endmodule

bind hop_list_ctrl hop_list_chk #(
    .IDX_W     (IDX_W),
    .OFS_W     (OFS_W),
    .OFS_LIMIT (OFS_LIMIT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_stb    (sym_stb),
    .hop_done   (hop_done),
    .cur_idx    (cur_idx),
    .offset_out (offset_out)
);

// File: tb/hop_list_ctrl_tb_top.sv
`timescale 1ns/1ps
module hop_list_ctrl_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [4:0]         wr_addr = '0;
    logic signed [24:0] wr_data = '0;
    logic [1:0]         hop_mode = 2'd0;
    logic [2:0]         pn_sel = 3'd0;
    logic [22:0]        pn_seed = '0;
    logic               seed_load = 1'b0;
    logic               hop_trig = 1'b0;
    logic [4:0]         ext_addr = '0;
    logic               sym_stb = 1'b0;
    logic [5:0]         list_len = 6'd32;
    logic [4:0]         cur_idx;
    logic signed [24:0] offset_out;
    logic               hop_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hop_list_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hop_mode(hop_mode), .pn_sel(pn_sel),
        .pn_seed(pn_seed), .seed_load(seed_load), .hop_trig(hop_trig),
        .ext_addr(ext_addr), .sym_stb(sym_stb), .list_len(list_len),
        .cur_idx(cur_idx), .offset_out(offset_out), .hop_done(hop_done)
    );

    // Bench-side reference values
    int                 exp_ofs [32];
    logic [22:0]        m_pn;
    int                 m_idx;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 10_000_000) return 10_000_000;
        if (v < -10_000_000) return -10_000_000;
        return v;
    endfunction

    function automatic int plen(input int sel);
        case (sel)
            0: return 9;
            1: return 11;
            2: return 15;
            3: return 16;
            4: return 20;
            5: return 21;
            default: return 23;
        endcase
    endfunction

    function automatic logic [22:0] msk(input int sel);
        return 23'((64'd1 << plen(sel)) - 1);
    endfunction

    function automatic logic [22:0] pn_next(input logic [22:0] s, input int sel);
        logic fb;
        logic [22:0] n;
        case (sel)
            0: fb = s[8] ^ s[4];
            1: fb = s[10] ^ s[8];
            2: fb = s[14] ^ s[13];
            3: fb = s[15] ^ s[14] ^ s[12] ^ s[3];
            4: fb = s[19] ^ s[2];
            5: fb = s[20] ^ s[18];
            default: fb = s[22] ^ s[17];
        endcase
        n = {s[21:0], fb} & msk(sel);
        return (n == 0) ? 23'd1 : n;
    endfunction

    function automatic int eff(input int l);
        return (l == 0 || l > 32) ? 32 : l;
    endfunction

    task automatic wr(input int a, input int v);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 25'(v);
        tick();
        wr_en = 1'b0;
        exp_ofs[a] = sat(v);
    endtask

    // Trigger, wait, accepting strobe, then a strobe that ends the hold-off
    task automatic do_hop(input logic [1:0] m, input int ea, input string req, input int exp_i);
        hop_mode = m; ext_addr = 5'(ea); hop_trig = 1'b1;
        tick();
        hop_trig = 1'b0;
        tick();
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        chk(req, cur_idx, exp_i);
        chk(req, offset_out, exp_ofs[exp_i]);
        chk("R3 hop_done pulse", hop_done, 1);
        m_idx = exp_i;
        tick();
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) exp_ofs[i] = 0;
        @(negedge clk);
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R2 reset state
        chk("R2 reset idx", cur_idx, 0);
        chk("R2 reset offset", offset_out, 0);
        chk("R2 reset hop_done", hop_done, 0);

        // R7 reset generator state 1; R6 first random index 1 % 7
        list_len = 6'd7;
        m_pn = 23'd1;
        do_hop(2'd1, 0, "R7 reset seed", int'(m_pn[4:0]) % 7);
        m_pn = pn_next(m_pn, 0);
        do_hop(2'd1, 0, "R6 step after reset", int'(m_pn[4:0]) % 7);

        // R1 sweep of writes incl. saturation, read back through R8 external hops
        list_len = 6'd32;
        for (int i = 0; i < 32; i++) wr(i, (i - 16) * 700_001);
        for (int i = 0; i < 32; i++) do_hop(2'd2, i, "R1 stored value via R8", i);
        wr(3, 10_000_000);
        wr(4, 10_000_001);
        wr(5, -10_000_001);
        do_hop(2'd2, 3, "R1 exact limit", 3);
        chk("R1 exact limit value", offset_out, 10_000_000);
        do_hop(2'd2, 4, "R1 above limit", 4);
        chk("R1 above limit value", offset_out, 10_000_000);
        do_hop(2'd2, 5, "R1 below limit", 5);
        chk("R1 below limit value", offset_out, -10_000_000);

        // R2 write to current entry shows next cycle
        wr(5, 1234);
        chk("R2 live update", offset_out, 1234);

        // R5 linear wrap for several lengths, mode 0 and 3
        for (int l = 1; l <= 6; l++) begin
            list_len = 6'(l);
            do_hop(2'd2, 0, "R8 set start", 0);
            for (int k = 0; k < 2 * l + 1; k++) begin
                do_hop((k % 2 == 0) ? 2'd0 : 2'd3, 0, "R5 linear wrap",
                       (m_idx + 1 >= l) ? 0 : m_idx + 1);
            end
        end

        // R9 length 0 and >32 behave as 32
        list_len = 6'd0;
        do_hop(2'd2, 31, "R9 len0 ext", 31);
        do_hop(2'd0, 0, "R9 len0 wrap", 0);
        list_len = 6'd40;
        do_hop(2'd2, 30, "R9 len40 ext", 30);
        do_hop(2'd0, 0, "R9 len40 step", 31);
        do_hop(2'd0, 0, "R9 len40 wrap", 0);

        // R8 modulo and capture at trigger
        list_len = 6'd20;
        do_hop(2'd2, 30, "R8 modulo", 10);
        hop_mode = 2'd2; ext_addr = 5'd9; hop_trig = 1'b1;
        tick();
        hop_trig = 1'b0; ext_addr = 5'd17;
        tick();
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        chk("R8 captured address", cur_idx, 9);
        tick(); sym_stb = 1'b1; tick(); sym_stb = 1'b0;

        // R6 and R7: every length code, several seeds
        list_len = 6'd7;
        for (int s = 0; s < 8; s++) begin
            pn_sel = 3'(s);
            pn_seed = 23'h2A5C3 + 23'(s * 977);
            seed_load = 1'b1;
            tick();
            seed_load = 1'b0;
            m_pn = pn_seed & msk(s);
            if (m_pn == 0) m_pn = 23'd1;
            for (int k = 0; k < 6; k++) begin
                do_hop(2'd1, 0, "R6 random index", int'(m_pn[4:0]) % 7);
                m_pn = pn_next(m_pn, s);
            end
        end
        // R7 zero seed replaced by 1
        pn_sel = 3'd0; pn_seed = 23'h7FFE00;
        seed_load = 1'b1;
        tick();
        seed_load = 1'b0;
        do_hop(2'd1, 0, "R7 zero seed", 1);
        do_hop(2'd1, 0, "R7 zero seed next", 2);

        // R4 hold-off: triggers in accept cycle, hold-off and clearing strobe dropped
        list_len = 6'd32;
        do_hop(2'd2, 0, "R8 set start", 0);
        hop_mode = 2'd0; hop_trig = 1'b1;
        tick();
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        chk("R4 accepted", cur_idx, 1);
        tick();
        hop_trig = 1'b0;
        tick();
        sym_stb = 1'b1; hop_trig = 1'b1;
        tick();
        sym_stb = 1'b0; hop_trig = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            sym_stb = 1'b1;
            tick();
            sym_stb = 1'b0;
            chk("R4 dropped trigger idx", cur_idx, 1);
            chk("R4 dropped trigger done", hop_done, 0);
        end
        hop_trig = 1'b1;
        tick();
        hop_trig = 1'b0; sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        chk("R4 trigger after hold-off", cur_idx, 2);
        tick(); sym_stb = 1'b1; tick(); sym_stb = 1'b0;

        // R3 pending held until strobe; trigger with strobe waits
        hop_trig = 1'b1;
        tick();
        hop_trig = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R3 pending idx", cur_idx, 2);
            chk("R3 pending done", hop_done, 0);
        end
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        chk("R3 accepted idx", cur_idx, 3);
        tick();
        chk("R3 pulse width", hop_done, 0);
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        tick();
        hop_trig = 1'b1; sym_stb = 1'b1;
        tick();
        hop_trig = 1'b0; sym_stb = 1'b0;
        chk("R3 trig with strobe waits", cur_idx, 3);
        tick();
        sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
        chk("R3 trig with strobe later", cur_idx, 4);
        tick();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule